// File: doc/BRIEF.md
# Asynchronous Pulse Input Conditioner

This block takes a vector of digital inputs that are not related to the local clock and makes them safe to use in that clock domain. Each input bit first passes through its own synchroniser chain. A glitch filter then accepts a new level only after the synchronised value has held steady for a set number of consecutive clock cycles.

Each channel drives three outputs. The first is the filtered level. The second is a pulse one clock wide that marks every accepted rising edge. The third is a stretched copy of that pulse whose length is set by a parameter. The filter length, the stretch length, the synchroniser depth and the channel count are all fixed when the block is built. A typical use is taking push-buttons, trigger lines or other slow external events into logic that wants either a clean level, a one-shot strobe or a pulse wide enough to be seen by a slower consumer.

Top module: `async_pulse_conditioner`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, every bit of `level_o`, `pulse_o` and `stretch_o` is 0 after that edge. The synchronisers and the filter counts are cleared as well.
- R2: Each input bit passes through SYNC_STAGES (default 2, minimum 2) flip-flops before the filter. With the defaults (SYNC_STAGES=2, FILT_LEN=4), a rising input that is set up before clock edge 1 raises `level_o` after edge 6 and not earlier.
- R3: A new level is accepted only after the synchronised input has shown it for FILT_LEN consecutive cycles. A run of FILT_LEN-1 cycles leaves `level_o` unchanged, and a run of exactly FILT_LEN cycles is accepted.
- R4: Any sample that equals the current filtered level restarts the count. Two runs of FILT_LEN-1 high cycles separated by one low cycle are rejected.
- R5: Falling transitions are filtered in the same way. A low run shorter than FILT_LEN keeps `level_o` high, and a held low clears it after SYNC_STAGES+FILT_LEN edges.
- R6: `pulse_o[i]` is high for exactly one cycle, in the first cycle in which `level_o[i]` is high. A falling filtered level produces no pulse.
- R7: `stretch_o[i]` goes high in the same cycle as `pulse_o[i]` and stays high for EXT_LEN (default 16) cycles.
- R8: An accepted rising edge that arrives while `stretch_o[i]` is already high reloads the count. The stretch then ends EXT_LEN cycles after the newer pulse.
- R9: Channels are independent: bit i of `async_in` affects only bit i of each output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| async_in | input | NUM_CH | Asynchronous inputs, one bit per channel |
| level_o | output | NUM_CH | Filtered level of each channel |
| pulse_o | output | NUM_CH | One-cycle strobe on each accepted rising edge |
| stretch_o | output | NUM_CH | Pulse lengthened to EXT_LEN cycles, re-armed by new edges |

## Verification
The properties assume that reset is held for at least one clock edge before any output is judged. They also assume that FILT_LEN is at least 2, so that two accepted edges of one channel can never fall on neighbouring cycles. Apart from that, the inputs may change at any time, because the checks only look at outputs that the synchronisers and the filter already stand between. The stimulus changes `async_in` only on falling clock edges, so that each input change counts as a whole number of sampled cycles. This lets the bench place every glitch, every run of exactly FILT_LEN cycles and every retrigger on a known edge.

// File: rtl/apc_pkg.sv
package apc_pkg;

    // Glitch filter: two settled states and two candidate states.
    typedef enum logic [1:0] {
        FLT_LOW  = 2'd0,
        FLT_RISE = 2'd1,
        FLT_HIGH = 2'd2,
        FLT_FALL = 2'd3
    } flt_state_e;

    // Pulse stretcher.
    typedef enum logic {
        STR_IDLE   = 1'b0,
        STR_ACTIVE = 1'b1
    } str_state_e;

endpackage

// File: rtl/apc_sync.sv
module apc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/apc_filter.sv
module apc_filter
    import apc_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    output logic rise_now,
    output logic level_q,
    output logic pulse_q
);

    localparam int            CW   = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    flt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          accept_rise;

    // Next-state decision.
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        accept_rise = 1'b0;
        unique case (state_q)
            FLT_LOW: begin
                if (sample) begin
                    state_d = FLT_RISE;
                    cnt_d   = ONE;
                end else begin
                    cnt_d   = '0;
                end
            end
            FLT_RISE: begin
                if (!sample) begin
                    state_d = FLT_LOW;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d     = FLT_HIGH;
                    cnt_d       = '0;
                    accept_rise = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            FLT_HIGH: begin
                if (!sample) begin
                    state_d = FLT_FALL;
                    cnt_d   = ONE;
                end else begin
                    cnt_d   = '0;
                end
            end
            FLT_FALL: begin
                if (sample) begin
                    state_d = FLT_HIGH;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = FLT_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLT_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            level_q <= (state_d == FLT_HIGH) || (state_d == FLT_FALL);
            pulse_q <= accept_rise;
        end
    end

    assign rise_now = accept_rise;

endmodule

// File: rtl/apc_stretch.sv
module apc_stretch
    import apc_pkg::*;
#(
    parameter int EXT_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic stretch_q
);

    localparam int            EW   = $clog2(EXT_LEN + 1);
    localparam logic [EW-1:0] LOAD = EW'(EXT_LEN - 1);
    localparam logic [EW-1:0] ONE  = EW'(1);

    str_state_e    state_q, state_d;
    logic [EW-1:0] cnt_q, cnt_d;

    // Next-state decision: a trigger always reloads the count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STR_IDLE: begin
                if (trig) begin
                    state_d = STR_ACTIVE;
                    cnt_d   = LOAD;
                end
            end
            STR_ACTIVE: begin
                if (trig) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = STR_IDLE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) begin
            stretch_q <= 1'b0;
        end else begin
            stretch_q <= (state_d == STR_ACTIVE);
        end
    end

endmodule

// File: rtl/apc_channel.sv
module apc_channel #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int EXT_LEN     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic level_out,
    output logic pulse_out,
    output logic stretch_out
);

    logic synced;
    logic rise_now;

    apc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_in),
        .q_out (synced)
    );

    apc_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .sample   (synced),
        .rise_now (rise_now),
        .level_q  (level_out),
        .pulse_q  (pulse_out)
    );

    apc_stretch #(.EXT_LEN(EXT_LEN)) u_stretch (
        .clk       (clk),
        .rst       (rst),
        .trig      (rise_now),
        .stretch_q (stretch_out)
    );

endmodule

// File: rtl/async_pulse_conditioner.sv
module async_pulse_conditioner #(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int EXT_LEN     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] async_in,
    output logic [NUM_CH-1:0] level_o,
    output logic [NUM_CH-1:0] pulse_o,
    output logic [NUM_CH-1:0] stretch_o
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        apc_channel #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .EXT_LEN     (EXT_LEN)
        ) u_ch (
            .clk         (clk),
            .rst         (rst),
            .raw_in      (async_in[ch]),
            .level_out   (level_o[ch]),
            .pulse_out   (pulse_o[ch]),
            .stretch_out (stretch_o[ch])
        );
    end

endmodule

// File: rtl/apc_checker.sv
module apc_checker #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] level_o,
    input logic [NUM_CH-1:0] pulse_o,
    input logic [NUM_CH-1:0] stretch_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (level_o == '0 && pulse_o == '0 && stretch_o == '0)); // R1

    AST_STRETCH_COVERS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (pulse_o & ~stretch_o) == '0); // R7

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            pulse_o[i] |=> !pulse_o[i]); // R6

        AST_PULSE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
            pulse_o[i] == (level_o[i] && !$past(level_o[i]))); // R6

        AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (level_o[i] != $past(level_o[i])) |=> (level_o[i] == $past(level_o[i]))); // R3
    end

endmodule

bind async_pulse_conditioner apc_checker #(.NUM_CH(NUM_CH)) u_apc_chk (
    .clk       (clk),
    .rst       (rst),
    .level_o   (level_o),
    .pulse_o   (pulse_o),
    .stretch_o (stretch_o)
);

// File: tb/tb_async_pulse_conditioner.sv
module tb_async_pulse_conditioner;

    localparam int NUM_CH = 4;
    localparam int SYNC   = 2;
    localparam int FILT   = 4;
    localparam int EXT    = 16;
    localparam int LAT    = SYNC + FILT;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_CH-1:0] ain = '0;
    logic [NUM_CH-1:0] level_o, pulse_o, stretch_o;

    int checks = 0;
    int errors = 0;

    async_pulse_conditioner #(
        .NUM_CH(NUM_CH), .SYNC_STAGES(SYNC), .FILT_LEN(FILT), .EXT_LEN(EXT)
    ) dut (
        .clk(clk), .rst(rst), .async_in(ain),
        .level_o(level_o), .pulse_o(pulse_o), .stretch_o(stretch_o)
    );

    always #2ns clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [NUM_CH-1:0] act, input logic [NUM_CH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R1", "level in reset", level_o, '0);
        check("R1", "pulse in reset", pulse_o, '0);
        check("R1", "stretch in reset", stretch_o, '0);
    endtask

    task automatic t_basic();
        ain[0] = 1'b1;
        tick(LAT - 1);
        check("R2", "level before latency", level_o, 4'b0000);
        tick(1);
        check("R2", "level at latency", level_o, 4'b0001);
        check("R6", "pulse at first high cycle", pulse_o, 4'b0001);
        check("R7", "stretch starts with pulse", stretch_o, 4'b0001);
        tick(1);
        check("R6", "pulse one cycle only", pulse_o, 4'b0000);
        for (int k = LAT + 1; k < LAT + EXT; k++) begin
            check("R7", "stretch held", stretch_o, 4'b0001);
            tick(1);
        end
        check("R7", "stretch ends after EXT cycles", stretch_o, 4'b0000);
        ain[0] = 1'b0;
        tick(LAT - 1);
        check("R5", "level before fall latency", level_o, 4'b0001);
        tick(1);
        check("R5", "level after held low", level_o, 4'b0000);
        check("R6", "no pulse on fall", pulse_o, 4'b0000);
        tick(4);
    endtask

    task automatic t_glitch();
        logic [NUM_CH-1:0] seen_l, seen_p;
        ain[1] = 1'b1;
        tick(FILT - 1);
        ain[1] = 1'b0;
        seen_l = '0; seen_p = '0;
        for (int k = 0; k < 12; k++) begin
            seen_l |= level_o; seen_p |= pulse_o;
            tick(1);
        end
        check("R3", "short run rejected (level)", seen_l, 4'b0000);
        check("R3", "short run rejected (pulse)", seen_p, 4'b0000);
        ain[1] = 1'b1;
        tick(FILT);
        ain[1] = 1'b0;
        seen_l = '0; seen_p = '0;
        for (int k = 0; k < 12; k++) begin
            seen_l |= level_o; seen_p |= pulse_o;
            tick(1);
        end
        check("R3", "exact run accepted (level)", seen_l, 4'b0010);
        check("R3", "exact run accepted (pulse)", seen_p, 4'b0010);
        tick(EXT + 4);
        check("R7", "idle after accepted run", stretch_o, 4'b0000);
    endtask

    task automatic t_restart();
        logic [NUM_CH-1:0] seen;
        ain[2] = 1'b1; tick(FILT - 1);
        ain[2] = 1'b0; tick(1);
        ain[2] = 1'b1; tick(FILT - 1);
        ain[2] = 1'b0;
        seen = '0;
        for (int k = 0; k < 14; k++) begin
            seen |= level_o | pulse_o | stretch_o;
            tick(1);
        end
        check("R4", "interrupted runs rejected", seen, 4'b0000);
    endtask

    task automatic t_fall_filter();
        logic [NUM_CH-1:0] all_l, any_p;
        ain[3] = 1'b1;
        tick(LAT);
        check("R5", "channel 3 high", level_o, 4'b1000);
        tick(EXT + 2);
        ain[3] = 1'b0; tick(FILT - 1);
        ain[3] = 1'b1;
        all_l = '1; any_p = '0;
        for (int k = 0; k < 12; k++) begin
            all_l &= level_o; any_p |= pulse_o;
            tick(1);
        end
        check("R5", "short low run keeps level", all_l & 4'b1000, 4'b1000);
        check("R6", "no pulse from rejected low run", any_p, 4'b0000);
        ain[3] = 1'b0;
        tick(LAT);
        check("R5", "held low clears level", level_o, 4'b0000);
        tick(4);
    endtask

    task automatic t_retrigger();
        logic [NUM_CH-1:0] el, ep, es;
        ain[0] = 1'b1;
        tick(LAT);
        ain[0] = 1'b0;
        tick(4);
        ain[0] = 1'b1;
        for (int k = LAT + 4; k <= 34; k++) begin
            el = ((k <= 11) || (k >= 16)) ? 4'b0001 : 4'b0000;
            ep = (k == 16) ? 4'b0001 : 4'b0000;
            es = (k <= 31) ? 4'b0001 : 4'b0000;
            check("R8", $sformatf("level cycle %0d", k), level_o, el);
            check("R8", $sformatf("pulse cycle %0d", k), pulse_o, ep);
            check("R8", $sformatf("stretch cycle %0d", k), stretch_o, es);
            tick(1);
        end
        ain[0] = 1'b0;
        tick(LAT + 2);
    endtask

    task automatic t_indep();
        ain[2] = 1'b1;
        tick(LAT);
        check("R9", "only channel 2 level", level_o, 4'b0100);
        check("R9", "only channel 2 pulse", pulse_o, 4'b0100);
        check("R9", "only channel 2 stretch", stretch_o, 4'b0100);
        ain[2] = 1'b0;
        tick(EXT + 4);
    endtask

    task automatic t_reset_mid();
        ain[1] = 1'b1;
        tick(LAT + 2);
        rst = 1'b1;
        tick(1);
        check("R1", "level cleared mid-run", level_o, '0);
        check("R1", "stretch cleared mid-run", stretch_o, '0);
        ain[1] = 1'b0;
        rst = 1'b0;
        tick(LAT + 2);
        check("R1", "stays clear after reset", level_o | pulse_o | stretch_o, '0);
    endtask

    initial begin
        #800us;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst = 1'b0;
        tick(1);
        t_basic();
        t_glitch();
        t_restart();
        t_fall_filter();
        t_retrigger();
        t_indep();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule